// File: doc/BRIEF.md
# Translation-Base System Register Access Arbiter

This block owns one 128-bit translation-base system register and settles how every software access to it ends. An access arrives as a decoded system-register encoding with a direction (read or write) and a width (64-bit single transfer or 128-bit paired transfer). It is qualified by the requester's privilege level and by the hypervisor and monitor control bits. The block resolves it into exactly one outcome: completed, undefined, trapped to level 2, trapped to level 3, or redirected to a memory slot.

The decision is purely combinational and is valid in the same cycle as the request. Only a completed write that targets this register changes the stored value, on the next rising clock edge. A 64-bit write touches only the low half. A 128-bit write loads both halves, with the upper half taken from the high transfer word. Reads return data only when the outcome is completed and the target is this register.

Top module: `sysreg_access_arb`

## Requirements
- R1: After synchronous reset the stored 128-bit value is zero, as seen by a 128-bit read at level 3.
- R2: A completed 64-bit write loads bits [63:0] only and leaves bits [127:64] as they were. A completed 64-bit read returns bits [63:0] on `rd_lo` and zero on `rd_hi`.
- R3: A completed 128-bit write loads `wr_hi` into bits [127:64] and `wr_lo` into bits [63:0]. A completed 128-bit read returns the upper half on `rd_hi` and the lower half on `rd_lo`.
- R4: Only two encodings are claimed: the primary one (op0=11, op1=000, CRn=0010, CRm=0000, op2=001) and the alias, which differs only in op1=101. Any other encoding, or `req_valid`=0, yields outcome 0 and no register change.
- R5: Any claimed access at privilege level 0 yields the undefined outcome.
- R6: At level 1 on the primary encoding, the checks run in strict order. With level 2 enabled, the coarse trap for the access direction traps to level 2. Next, with level 2 enabled, the fine-grained bit for the direction traps to level 2, but only when level 3 is absent or the monitor fine-grained enable is 1. Next, a virtualisation triple of 111 redirects. Otherwise the access completes.
- R7: The syndrome class is 0x18 for a trap raised by a 64-bit access and 0x14 for one raised by a 128-bit access. It is zero for every non-trap outcome.
- R8: For 128-bit accesses, with level 3 present and the monitor wide enable at 0, the access is undefined if `undef_first` is 1 and traps to level 3 otherwise. The undefined case outranks all level-1 traps. At level 1 with level 2 enabled, the access also traps to level 2 when the extended control is not valid or the hypervisor wide enable is 0. This check is placed after the fine-grained check and before the level-3 trap.
- R9: At level 2 in host mode, a completed primary access sets `tgt_l2`=1 and neither writes nor returns this register. At level 3 a primary access always completes with `tgt_l2`=0.
- R10: For the alias at level 1, a triple of 101 redirects. Otherwise a triple with bit 0 set traps to level 2. Otherwise the access is undefined.
- R11: For the alias at levels 2 and 3, the access is undefined unless host mode is set. In host mode it reaches this register; a 128-bit alias access at level 2 is still subject to the monitor wide enable of R8.
- R12: The outcome vector has at most one bit set (bit0 completed, bit1 undefined, bit2 trap to level 2, bit3 trap to level 3, bit4 redirect). A write whose outcome is not completed leaves the register unchanged.
- R13: `redir_off` is 0x210 exactly when the outcome is redirect, and zero otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wide | input | 1 | 1 = 128-bit paired access |
| enc_op0 | input | 2 | Encoding field op0 |
| enc_op1 | input | 3 | Encoding field op1 |
| enc_crn | input | 4 | Encoding field CRn |
| enc_crm | input | 4 | Encoding field CRm |
| enc_op2 | input | 3 | Encoding field op2 |
| priv_lvl | input | 2 | Current privilege level 0..3 |
| lvl2_on | input | 1 | Level 2 enabled in current state |
| lvl3_here | input | 1 | Level 3 implemented |
| hv_rd_trap | input | 1 | Hypervisor coarse read trap |
| hv_wr_trap | input | 1 | Hypervisor coarse write trap |
| fg_rd_trap | input | 1 | Fine-grained read trap bit |
| fg_wr_trap | input | 1 | Fine-grained write trap bit |
| mon_fg_en | input | 1 | Monitor fine-grained trap enable |
| nv_bits | input | 3 | Nested-virtualisation triple |
| host_mode | input | 1 | Level 2 running as host |
| mon_wide_en | input | 1 | Monitor 128-bit access enable |
| hv_wide_en | input | 1 | Hypervisor 128-bit access enable |
| hv_ext_ok | input | 1 | Extended hypervisor control valid |
| undef_first | input | 1 | Undefined takes priority over monitor trap |
| wr_lo | input | 64 | Write data, low transfer word |
| wr_hi | input | 64 | Write data, high transfer word |
| outcome | output | 5 | One-hot outcome |
| syndrome | output | 6 | Trap syndrome class |
| tgt_l2 | output | 1 | Access targets level-2 counterpart |
| redir_off | output | 12 | Memory redirect offset |
| rd_lo | output | 64 | Read data, low word |
| rd_hi | output | 64 | Read data, high word |

## Verification
The outcome, syndrome, target flag, redirect offset and read data all settle in the same cycle as the request. The bench drives each request on a falling edge and samples these one time unit later, well before the next rising edge. Stored contents change only at the rising edge that follows a completed write. The bench therefore checks any write's effect with a separate read issued on the following falling edge, so every check falls in exactly one cycle with no ordering dependence on the clock edge.

// File: rtl/sra_pkg.sv
package sra_pkg;

    typedef enum logic [4:0] {
        OC_NONE  = 5'b00000,
        OC_DONE  = 5'b00001,
        OC_UNDEF = 5'b00010,
        OC_TRAP2 = 5'b00100,
        OC_TRAP3 = 5'b01000,
        OC_REDIR = 5'b10000
    } outcome_e;

    localparam logic [5:0]  EC_NARROW = 6'h18;
    localparam logic [5:0]  EC_WIDE   = 6'h14;
    localparam logic [11:0] NV_SLOT   = 12'h210;
    localparam int unsigned N_ENC     = 2;

    typedef struct packed {
        logic [1:0] op0;
        logic [2:0] op1;
        logic [3:0] crn;
        logic [3:0] crm;
        logic [2:0] op2;
    } enc_t;

    localparam enc_t ENC_PRIMARY = '{op0: 2'b11, op1: 3'b000, crn: 4'b0010, crm: 4'b0000, op2: 3'b001};
    localparam enc_t ENC_ALIAS   = '{op0: 2'b11, op1: 3'b101, crn: 4'b0010, crm: 4'b0000, op2: 3'b001};

    typedef struct packed {
        logic       lvl2_on;
        logic       lvl3_here;
        logic       hv_rd_trap;
        logic       hv_wr_trap;
        logic       fg_rd_trap;
        logic       fg_wr_trap;
        logic       mon_fg_en;
        logic [2:0] nv;
        logic       host;
        logic       mon_wide_en;
        logic       hv_wide_en;
        logic       hv_ext_ok;
        logic       undef_first;
    } ctl_t;

    typedef struct packed {
        outcome_e    oc;
        logic [5:0]  syn;
        logic        tgt_l2;
        logic [11:0] off;
    } verdict_t;

    function automatic enc_t enc_entry(input int unsigned idx);
        return (idx == 0) ? ENC_PRIMARY : ENC_ALIAS;
    endfunction

endpackage

// File: rtl/sra_decode.sv
module sra_decode
    import sra_pkg::*;
(
    input  enc_t             enc,
    output logic [N_ENC-1:0] hit
);
    for (genvar g = 0; g < N_ENC; g++) begin : g_match
        localparam enc_t REF = enc_entry(g);
        assign hit[g] = (enc == REF);
    end
endmodule

// File: rtl/sra_resolve.sv
module sra_resolve
    import sra_pkg::*;
(
    input  logic       valid,
    input  logic       hit_pri,
    input  logic       hit_ali,
    input  logic [1:0] lvl,
    input  logic       wr,
    input  logic       wide,
    input  ctl_t       ctl,
    output verdict_t   vd
);
    logic coarse, fine, mon_block, mon_undef, hyp_block;
    outcome_e oc;
    logic tgt;

    always_comb begin
        coarse    = wr ? ctl.hv_wr_trap : ctl.hv_rd_trap;
        fine      = (wr ? ctl.fg_wr_trap : ctl.fg_rd_trap) & (~ctl.lvl3_here | ctl.mon_fg_en);
        mon_block = wide & ctl.lvl3_here & ~ctl.mon_wide_en;
        mon_undef = mon_block & ctl.undef_first;
        hyp_block = wide & ctl.lvl2_on & (~ctl.hv_ext_ok | ~ctl.hv_wide_en);
        oc  = OC_NONE;
        tgt = 1'b0;
        if (valid && (hit_pri || hit_ali)) begin
            if (lvl == 2'd0) begin
                oc = OC_UNDEF;
            end else if (hit_pri) begin
                if (lvl == 2'd1) begin
                    if (mon_undef)                  oc = OC_UNDEF;
                    else if (ctl.lvl2_on && coarse) oc = OC_TRAP2;
                    else if (ctl.lvl2_on && fine)   oc = OC_TRAP2;
                    else if (hyp_block)             oc = OC_TRAP2;
                    else if (mon_block)             oc = OC_TRAP3;
                    else if (ctl.nv == 3'b111)      oc = OC_REDIR;
                    else                            oc = OC_DONE;
                end else if (lvl == 2'd2) begin
                    if (mon_undef)      oc = OC_UNDEF;
                    else if (mon_block) oc = OC_TRAP3;
                    else begin
                        oc  = OC_DONE;
                        tgt = ctl.host;
                    end
                end else begin
                    oc = OC_DONE;
                end
            end else begin
                if (lvl == 2'd1) begin
                    if (ctl.nv == 3'b101) oc = OC_REDIR;
                    else if (ctl.nv[0])   oc = OC_TRAP2;
                    else                  oc = OC_UNDEF;
                end else if (lvl == 2'd2) begin
                    if (!ctl.host)      oc = OC_UNDEF;
                    else if (mon_undef) oc = OC_UNDEF;
                    else if (mon_block) oc = OC_TRAP3;
                    else                oc = OC_DONE;
                end else begin
                    oc = ctl.host ? OC_DONE : OC_UNDEF;
                end
            end
        end
        vd.oc     = oc;
        vd.tgt_l2 = tgt;
        vd.syn    = (oc == OC_TRAP2 || oc == OC_TRAP3) ? (wide ? EC_WIDE : EC_NARROW) : 6'h00;
        vd.off    = (oc == OC_REDIR) ? NV_SLOT : 12'h000;
    end
endmodule

// File: rtl/sra_store.sv
module sra_store #(
    parameter int unsigned XLEN = 64,
    localparam int unsigned NHALF = 2
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [NHALF-1:0]      we,
    input  logic [NHALF*XLEN-1:0] wd,
    output logic [NHALF*XLEN-1:0] q
);
    for (genvar h = 0; h < NHALF; h++) begin : g_half
        always_ff @(posedge clk) begin
            if (rst)        q[h*XLEN +: XLEN] <= '0;
            else if (we[h]) q[h*XLEN +: XLEN] <= wd[h*XLEN +: XLEN];
        end
    end
endmodule

// File: rtl/sysreg_access_arb.sv
module sysreg_access_arb
    import sra_pkg::*;
#(
    parameter int unsigned XLEN = 64,
    localparam int unsigned RW = 2 * XLEN
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            req_valid,
    input  logic            req_write,
    input  logic            req_wide,
    input  logic [1:0]      enc_op0,
    input  logic [2:0]      enc_op1,
    input  logic [3:0]      enc_crn,
    input  logic [3:0]      enc_crm,
    input  logic [2:0]      enc_op2,
    input  logic [1:0]      priv_lvl,
    input  logic            lvl2_on,
    input  logic            lvl3_here,
    input  logic            hv_rd_trap,
    input  logic            hv_wr_trap,
    input  logic            fg_rd_trap,
    input  logic            fg_wr_trap,
    input  logic            mon_fg_en,
    input  logic [2:0]      nv_bits,
    input  logic            host_mode,
    input  logic            mon_wide_en,
    input  logic            hv_wide_en,
    input  logic            hv_ext_ok,
    input  logic            undef_first,
    input  logic [XLEN-1:0] wr_lo,
    input  logic [XLEN-1:0] wr_hi,
    output logic [4:0]      outcome,
    output logic [5:0]      syndrome,
    output logic            tgt_l2,
    output logic [11:0]     redir_off,
    output logic [XLEN-1:0] rd_lo,
    output logic [XLEN-1:0] rd_hi
);
    enc_t             enc;
    ctl_t             ctl;
    logic [N_ENC-1:0] hit;
    verdict_t         vd;
    logic [RW-1:0]    reg_q;
    logic             local_done, commit, rd_ok;

    assign enc = '{op0: enc_op0, op1: enc_op1, crn: enc_crn, crm: enc_crm, op2: enc_op2};
    assign ctl = '{lvl2_on: lvl2_on, lvl3_here: lvl3_here, hv_rd_trap: hv_rd_trap,
                   hv_wr_trap: hv_wr_trap, fg_rd_trap: fg_rd_trap, fg_wr_trap: fg_wr_trap,
                   mon_fg_en: mon_fg_en, nv: nv_bits, host: host_mode,
                   mon_wide_en: mon_wide_en, hv_wide_en: hv_wide_en,
                   hv_ext_ok: hv_ext_ok, undef_first: undef_first};

    sra_decode u_dec (.enc(enc), .hit(hit));

    sra_resolve u_res (
        .valid(req_valid), .hit_pri(hit[0]), .hit_ali(hit[1]),
        .lvl(priv_lvl), .wr(req_write), .wide(req_wide), .ctl(ctl), .vd(vd)
    );

    assign local_done = (vd.oc == OC_DONE) && !vd.tgt_l2;
    assign commit     = local_done && req_write;
    assign rd_ok      = local_done && !req_write;

    sra_store #(.XLEN(XLEN)) u_store (
        .clk(clk), .rst(rst),
        .we({commit & req_wide, commit}),
        .wd({wr_hi, wr_lo}),
        .q(reg_q)
    );

    assign outcome   = vd.oc;
    assign syndrome  = vd.syn;
    assign tgt_l2    = vd.tgt_l2;
    assign redir_off = vd.off;
    assign rd_lo     = rd_ok ? reg_q[XLEN-1:0] : '0;
    assign rd_hi     = (rd_ok && req_wide) ? reg_q[RW-1:XLEN] : '0;
endmodule

// File: rtl/sra_chk.sv
module sra_chk #(
    parameter int unsigned XLEN = 64
) (
    input logic            clk,
    input logic            rst,
    input logic            req_valid,
    input logic            req_write,
    input logic            req_wide,
    input logic [1:0]      priv_lvl,
    input logic            host_mode,
    input logic [4:0]      outcome,
    input logic [5:0]      syndrome,
    input logic            tgt_l2,
    input logic [11:0]     redir_off,
    input logic [2*XLEN-1:0] reg_q
);
    // R12
    outcome_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(outcome));

    // R4
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !req_valid |-> (outcome == 5'b00000));

    // R5
    lvl0_undef_chk: assert property (@(posedge clk) disable iff (rst)
        (priv_lvl == 2'd0 && outcome != 5'b00000) |-> (outcome == 5'b00010));

    // R7
    trap_class_chk: assert property (@(posedge clk) disable iff (rst)
        (outcome[2] || outcome[3]) |-> (syndrome == (req_wide ? 6'h14 : 6'h18)));

    // R7
    no_trap_class_chk: assert property (@(posedge clk) disable iff (rst)
        !(outcome[2] || outcome[3]) |-> (syndrome == 6'h00));

    // R13
    redir_off_chk: assert property (@(posedge clk) disable iff (rst)
        (redir_off != 12'h000) == outcome[4]);

    // R9
    counterpart_chk: assert property (@(posedge clk) disable iff (rst)
        tgt_l2 |-> (outcome[0] && priv_lvl == 2'd2 && host_mode));

    // R2
    narrow_keeps_hi_chk: assert property (@(posedge clk) disable iff (rst)
        (req_write && !req_wide) |=> $stable(reg_q[2*XLEN-1:XLEN]));

    // R12
    blocked_write_chk: assert property (@(posedge clk) disable iff (rst)
        (!(outcome[0] && req_write) || tgt_l2) |=> $stable(reg_q));
endmodule

bind sysreg_access_arb sra_chk #(.XLEN(XLEN)) i_chk (.*);

// File: tb/test_sysreg_access_arb.sv
module test_sysreg_access_arb;
    localparam int XL = 64;
    localparam logic [4:0] DN = 5'b00001, UN = 5'b00010, T2 = 5'b00100, T3 = 5'b01000, RD = 5'b10000;

    // ctl order: lvl2_on lvl3 hrd hwr frd fwr mfg _ nv _ host mwide hwide hext ufirst
    typedef struct packed {
        logic [1:0]  lvl;
        logic        wr;
        logic        wide;
        logic        ali;
        logic [16:0] ctl;
        logic [4:0]  oc;
        logic [5:0]  syn;
        logic        tgt;
    } vec_t;

    localparam int NV = 22;
    localparam vec_t VT [NV] = '{
        '{2'd0, 1'b0, 1'b0, 1'b0, 17'b0000000_000_00000, UN, 6'h00, 1'b0}, // R5
        '{2'd1, 1'b0, 1'b0, 1'b0, 17'b1010100_111_00000, T2, 6'h18, 1'b0}, // R6 coarse first
        '{2'd1, 1'b0, 1'b0, 1'b0, 17'b1100100_111_00000, RD, 6'h00, 1'b0}, // R6 fine gated off
        '{2'd1, 1'b0, 1'b0, 1'b0, 17'b1000100_000_00000, T2, 6'h18, 1'b0}, // R6 fine
        '{2'd1, 1'b1, 1'b0, 1'b0, 17'b1010000_000_00000, DN, 6'h00, 1'b0}, // R6 read trap on write
        '{2'd1, 1'b0, 1'b0, 1'b0, 17'b0010100_000_00000, DN, 6'h00, 1'b0}, // R6 lvl2 off
        '{2'd1, 1'b0, 1'b1, 1'b0, 17'b1110000_000_00001, UN, 6'h00, 1'b0}, // R8 undef first
        '{2'd1, 1'b0, 1'b1, 1'b0, 17'b1100000_000_00110, T3, 6'h14, 1'b0}, // R8 trap3
        '{2'd1, 1'b1, 1'b1, 1'b0, 17'b1000000_000_00100, T2, 6'h14, 1'b0}, // R8 ext invalid
        '{2'd1, 1'b1, 1'b1, 1'b0, 17'b1001000_000_00110, T2, 6'h14, 1'b0}, // R7 wide coarse
        '{2'd1, 1'b0, 1'b1, 1'b0, 17'b1100000_111_01110, RD, 6'h00, 1'b0}, // R13 wide redirect
        '{2'd2, 1'b0, 1'b0, 1'b0, 17'b0000000_000_10000, DN, 6'h00, 1'b1}, // R9 host
        '{2'd2, 1'b0, 1'b1, 1'b0, 17'b0100000_000_10000, T3, 6'h14, 1'b0}, // R8 lvl2
        '{2'd3, 1'b1, 1'b0, 1'b0, 17'b0000000_000_10000, DN, 6'h00, 1'b0}, // R9 lvl3
        '{2'd1, 1'b0, 1'b0, 1'b1, 17'b0000000_101_00000, RD, 6'h00, 1'b0}, // R10 redirect
        '{2'd1, 1'b0, 1'b0, 1'b1, 17'b0000000_111_00000, T2, 6'h18, 1'b0}, // R10 trap
        '{2'd1, 1'b0, 1'b0, 1'b1, 17'b0000000_100_00000, UN, 6'h00, 1'b0}, // R10 undef
        '{2'd2, 1'b0, 1'b0, 1'b1, 17'b0000000_000_00000, UN, 6'h00, 1'b0}, // R11 no host
        '{2'd3, 1'b0, 1'b0, 1'b1, 17'b0000000_000_10000, DN, 6'h00, 1'b0}, // R11 host
        '{2'd1, 1'b0, 1'b1, 1'b1, 17'b0000000_011_00000, T2, 6'h14, 1'b0}, // R10 wide
        '{2'd2, 1'b0, 1'b0, 1'b0, 17'b0000000_000_00000, DN, 6'h00, 1'b0}, // R9 no host
        '{2'd2, 1'b0, 1'b1, 1'b1, 17'b0100000_000_10001, UN, 6'h00, 1'b0}  // R11 wide monitor
    };

    logic clk = 1'b0, rst = 1'b1;
    logic req_valid, req_write, req_wide;
    logic [1:0] enc_op0; logic [2:0] enc_op1; logic [3:0] enc_crn, enc_crm; logic [2:0] enc_op2;
    logic [1:0] priv_lvl;
    logic lvl2_on, lvl3_here, hv_rd_trap, hv_wr_trap, fg_rd_trap, fg_wr_trap, mon_fg_en;
    logic [2:0] nv_bits;
    logic host_mode, mon_wide_en, hv_wide_en, hv_ext_ok, undef_first;
    logic [XL-1:0] wr_lo, wr_hi, rd_lo, rd_hi;
    logic [4:0] outcome; logic [5:0] syndrome; logic tgt_l2; logic [11:0] redir_off;

    int checks = 0, fails = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    sysreg_access_arb i_sysreg_access_arb (.*);

    task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic apply(input vec_t v, input logic valid, input logic [XL-1:0] lo, input logic [XL-1:0] hi);
        req_valid = valid; req_write = v.wr; req_wide = v.wide; priv_lvl = v.lvl;
        enc_op0 = 2'b11; enc_op1 = v.ali ? 3'b101 : 3'b000;
        enc_crn = 4'b0010; enc_crm = 4'b0000; enc_op2 = 3'b001;
        {lvl2_on, lvl3_here, hv_rd_trap, hv_wr_trap, fg_rd_trap, fg_wr_trap, mon_fg_en,
         nv_bits, host_mode, mon_wide_en, hv_wide_en, hv_ext_ok, undef_first} = v.ctl;
        wr_lo = lo; wr_hi = hi;
    endtask

    function automatic vec_t mk(input logic [1:0] lvl, input logic wr, input logic wide, input logic [16:0] ctl);
        vec_t v = '0;
        v.lvl = lvl; v.wr = wr; v.wide = wide; v.ctl = ctl;
        return v;
    endfunction

    // one request per cycle: drive at falling edge, sample 1 time unit later
    task automatic step(input vec_t v, input logic [XL-1:0] lo, input logic [XL-1:0] hi);
        @(negedge clk);
        apply(v, 1'b1, lo, hi);
        #1;
    endtask

    task automatic read_all(input string tag, input logic [127:0] exp);
        step(mk(2'd3, 1'b0, 1'b1, 17'd0), '0, '0);
        chk(tag, {rd_hi, rd_lo}, exp);
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        apply(mk(2'd0, 1'b0, 1'b0, 17'd0), 1'b0, '0, '0);
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;

        // R1 reset value
        read_all("R1 reset zero", 128'd0);
        // R4 idle request
        @(negedge clk); apply(mk(2'd3, 1'b1, 1'b1, 17'd0), 1'b0, 64'hFF, 64'hFF); #1;
        chk("R4 idle outcome", {123'd0, outcome}, 128'd0);
        read_all("R4 idle no write", 128'd0);

        for (int i = 0; i < NV; i++) begin
            step(VT[i], '0, '0);
            chk($sformatf("R6-table[%0d] outcome", i), {123'd0, outcome}, {123'd0, VT[i].oc});
            chk($sformatf("R7 table[%0d] syndrome", i), {122'd0, syndrome}, {122'd0, VT[i].syn});
            chk($sformatf("R9 table[%0d] target", i), {127'd0, tgt_l2}, {127'd0, VT[i].tgt});
            chk($sformatf("R13 table[%0d] offset", i), {116'd0, redir_off},
                {116'd0, (VT[i].oc == RD) ? 12'h210 : 12'h000});
        end

        // R3 wide write then wide read
        step(mk(2'd3, 1'b1, 1'b1, 17'd0), 64'h1111_2222_3333_4444, 64'hAAAA_BBBB_CCCC_DDDD);
        read_all("R3 wide round trip", {64'hAAAA_BBBB_CCCC_DDDD, 64'h1111_2222_3333_4444});

        // R2 narrow write keeps upper half
        step(mk(2'd3, 1'b1, 1'b0, 17'd0), 64'h5555_6666_7777_8888, 64'hFFFF_FFFF_FFFF_FFFF);
        read_all("R2 narrow write low only", {64'hAAAA_BBBB_CCCC_DDDD, 64'h5555_6666_7777_8888});
        step(mk(2'd3, 1'b0, 1'b0, 17'd0), '0, '0);
        chk("R2 narrow read", {rd_hi, rd_lo}, {64'd0, 64'h5555_6666_7777_8888});

        // R12 trapped write leaves register alone
        step(mk(2'd1, 1'b1, 1'b1, 17'b1001000_000_00110), 64'h1, 64'h2);
        chk("R12 trapped write outcome", {123'd0, outcome}, {123'd0, T2});
        read_all("R12 trapped write ignored", {64'hAAAA_BBBB_CCCC_DDDD, 64'h5555_6666_7777_8888});

        // R9 host write at lvl2 goes to counterpart
        step(mk(2'd2, 1'b1, 1'b1, 17'b0000000_000_10000), 64'h3, 64'h4);
        chk("R9 host write target", {127'd0, tgt_l2}, 128'd1);
        read_all("R9 counterpart write ignored", {64'hAAAA_BBBB_CCCC_DDDD, 64'h5555_6666_7777_8888});

        // R13 redirected write does not land
        step(mk(2'd1, 1'b1, 1'b0, 17'b0000000_111_00000), 64'h9, 64'h0);
        chk("R13 redirect write", {116'd0, redir_off}, {116'd0, 12'h210});
        read_all("R13 redirect write ignored", {64'hAAAA_BBBB_CCCC_DDDD, 64'h5555_6666_7777_8888});

        // R4 foreign encoding
        @(negedge clk);
        apply(mk(2'd3, 1'b1, 1'b1, 17'd0), 1'b1, 64'h7, 64'h7);
        enc_op1 = 3'b010; #1;
        chk("R4 foreign encoding outcome", {123'd0, outcome}, 128'd0);
        read_all("R4 foreign write ignored", {64'hAAAA_BBBB_CCCC_DDDD, 64'h5555_6666_7777_8888});

        // R11 alias write at lvl3 host lands
        @(negedge clk);
        apply(mk(2'd3, 1'b1, 1'b1, 17'b0000000_000_10000), 1'b1, 64'hC0DE, 64'hBEEF);
        enc_op1 = 3'b101; #1;
        chk("R11 alias host write", {123'd0, outcome}, {123'd0, DN});
        read_all("R11 alias write landed", {64'hBEEF, 64'hC0DE});

        // R1 reset mid-run
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        read_all("R1 reset clears", 128'd0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule